// File: doc/BRIEF.md
# Dual-Channel Converter Result Read Port

This block is one board's side of a shared backplane read bus. The board carries two 16-bit conversion channels, A and B. Each channel has a holding register that takes the converter's result when that channel's transfer strobe goes from low to high. The strobes arrive as levels and are edge-detected on the system clock. A reader on the backplane asks for a result with a 5-bit read select and a read enable. The lowest select bit names the channel. The upper four bits name a board.

The board's identity comes from four jumper lines. A fitted jumper reads as 0 and an open one reads as 1, so the board number is the bitwise inverse of the jumper levels. Up to sixteen boards can share the bus, which gives 32 contiguous read slots. A board drives the bus only in the cycle that follows a matching request. When it does not drive, it holds its enable low and presents zero on its data lines, so the outputs of several instances can be OR-combined.

Top module: `adc_readout_mux`

## Requirements
- R1: A rising edge on xfer_a, seen at a clock edge, loads conv_a into channel A's holding register at that same clock edge.
- R2: A rising edge on xfer_b loads conv_b into channel B's holding register, and channel A's register is left unchanged.
- R3: While a transfer strobe stays high, no further capture happens. A change on the result bus has no effect until the strobe falls and rises again.
- R4: Read select bit 0 chooses the channel: 0 selects channel A and 1 selects channel B.
- R5: The board responds only when rd_sel[4:1] equals the bitwise inverse of jmp_n[3:0]. For example, jmp_n=4'b1010 gives board 5 (slots 0x0A and 0x0B), jmp_n=4'b1111 gives board 0, and jmp_n=4'b0000 gives board 15.
- R6: While rd_en is low, the board never drives, whatever the select value.
- R7: When bus_oe is low, bus_data is all zeros.
- R8: A matching request in one cycle makes bus_oe high and bus_data valid in the next cycle, and only in that cycle. Back-to-back requests give back-to-back results.
- R9: If a strobe rising edge and a read of the same channel fall in the same cycle, the read returns the value held before that capture.
- R10: After reset, both holding registers read zero and bus_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| conv_a | input | 16 | Converter result, channel A |
| conv_b | input | 16 | Converter result, channel B |
| xfer_a | input | 1 | Transfer strobe level, channel A |
| xfer_b | input | 1 | Transfer strobe level, channel B |
| rd_sel | input | 5 | Read slot: [4:1] board number, [0] channel |
| rd_en | input | 1 | Read request qualifier |
| jmp_n | input | 4 | Board jumper levels (fitted = 0) |
| bus_data | output | 16 | Read data, zero when not driving |
| bus_oe | output | 1 | Drive enable for bus_data |

## Verification
The hardest case to reach is a capture and a read of the same channel landing on one clock edge, where the answer must be the older value. The bench drives the strobe rise and the matching read request in the same cycle. It then reads again on the next cycle to see that the new value did arrive. Board decoding is tested by changing the jumper levels in the middle of the run and reading the lowest slot pair, the highest slot pair and a slot of a neighbouring board.

// File: rtl/adcrd_pkg.sv
`timescale 1ns/1ps
package adcrd_pkg;
  // Channel code carried in the lowest read-select bit
  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;

  localparam int unsigned CH_BITS = 1;
  localparam int unsigned NUM_CH  = 2 ** CH_BITS;
endpackage

// File: rtl/adcrd_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of the active-low reset
module adcrd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/adcrd_capture.sv
`timescale 1ns/1ps
// One channel: strobe edge detect plus result holding register
module adcrd_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] hold
);
  logic              strobe_q;
  logic              rise;
  logic [DATA_W-1:0] hold_d;

  always_comb begin
    rise   = strobe & ~strobe_q;
    hold_d = hold;
    if (rise) hold_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      hold     <= '0;
    end else begin
      strobe_q <= strobe;
      if (rise) hold <= hold_d;
    end
  end

  // R1/R2: an edge loads the bus value present at that clock edge
  a_r1_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !strobe_q) |=> (hold == $past(din)));

  // R3: a strobe held high leaves the register alone
  a_r3_no_capture_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && strobe_q) |=> $stable(hold));
endmodule

// File: rtl/adcrd_decode.sv
`timescale 1ns/1ps
// Board/channel decode of the read select against the jumper levels
module adcrd_decode
  import adcrd_pkg::*;
#(
  parameter int unsigned SEL_W = 5
) (
  input  logic [SEL_W-1:0]         sel,
  input  logic [SEL_W-CH_BITS-1:0] jmp_n,
  input  logic                     rd_en,
  output logic                     req,
  output chan_e                    chan
);
  localparam int unsigned BRD_W = SEL_W - CH_BITS;

  logic [BRD_W-1:0] board_id;

  always_comb begin
    board_id = ~jmp_n;
    req      = rd_en && (sel[SEL_W-1:CH_BITS] == board_id);
    chan     = chan_e'(sel[CH_BITS-1:0]);
  end
endmodule

// File: rtl/adcrd_drive.sv
`timescale 1ns/1ps
// Registered bus driver: one cycle after a matching request
module adcrd_drive
  import adcrd_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req,
  input  chan_e                          chan,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  hold,
  output logic [DATA_W-1:0]              data,
  output logic                           oe
);
  logic              oe_d;
  logic [DATA_W-1:0] data_d;
  logic              upd_en;

  always_comb begin
    oe_d   = req;
    data_d = '0;
    if (req) data_d = hold[chan];
    upd_en = req | oe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe   <= 1'b0;
      data <= '0;
    end else if (upd_en) begin
      oe   <= oe_d;
      data <= data_d;
    end
  end

  // R7: idle bus lines are zero
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (data == '0));

  // R8: a request is answered in the following cycle
  a_r8_one_cycle_grant: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> oe);

  // R6/R8: no request, no drive next cycle
  a_r6_no_req_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !oe);

  // R4/R9: value is the selected register as it stood at the request edge
  a_r4_channel_value: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (data == $past(hold[chan])));
endmodule

// File: rtl/adc_readout_mux.sv
`timescale 1ns/1ps
module adc_readout_mux
  import adcrd_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DATA_W-1:0]        conv_a,
  input  logic [DATA_W-1:0]        conv_b,
  input  logic                     xfer_a,
  input  logic                     xfer_b,
  input  logic [SEL_W-1:0]         rd_sel,
  input  logic                     rd_en,
  input  logic [SEL_W-CH_BITS-1:0] jmp_n,
  output logic [DATA_W-1:0]        bus_data,
  output logic                     bus_oe
);
  localparam int unsigned BRD_W = SEL_W - CH_BITS;

  logic                          rst_sync_n;
  logic [NUM_CH-1:0]             strobe_v;
  logic [NUM_CH-1:0][DATA_W-1:0] din_v;
  logic [NUM_CH-1:0][DATA_W-1:0] hold_v;
  logic                          req;
  chan_e                         chan;

  assign strobe_v = {xfer_b, xfer_a};
  assign din_v    = {conv_b, conv_a};

  adcrd_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_sync_n)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    adcrd_capture #(.DATA_W(DATA_W)) u_cap (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .strobe(strobe_v[g]),
      .din   (din_v[g]),
      .hold  (hold_v[g])
    );
  end

  adcrd_decode #(.SEL_W(SEL_W)) u_dec (
    .sel  (rd_sel),
    .jmp_n(jmp_n),
    .rd_en(rd_en),
    .req  (req),
    .chan (chan)
  );

  adcrd_drive #(.DATA_W(DATA_W)) u_drv (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .req  (req),
    .chan (chan),
    .hold (hold_v),
    .data (bus_data),
    .oe   (bus_oe)
  );

  // R5: driving implies the previous select named this board
  a_r5_board_match: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_oe |-> ($past(rd_sel[SEL_W-1:CH_BITS]) == ~$past(jmp_n)));

  // R6: driving implies rd_en was high
  a_r6_enable_needed: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_oe |-> $past(rd_en));

  // R10: holding registers clear under reset
  a_r10_reset_clear: assert property (@(posedge clk)
    !rst_sync_n |-> (hold_v == '0 && !bus_oe));

  logic [BRD_W-1:0] unused_brd;
  assign unused_brd = '0;
endmodule

// File: tb/sim_adc_readout_mux.sv
`timescale 1ns/1ps
module sim_adc_readout_mux;
  typedef struct {
    logic        oe;
    logic [15:0] d;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] conv_a, conv_b;
  logic        xfer_a, xfer_b;
  logic [4:0]  rd_sel;
  logic        rd_en;
  logic [3:0]  jmp_n;
  logic [15:0] bus_data;
  logic        bus_oe;

  int total = 0;
  int bad   = 0;
  exp_t q[$];

  logic [15:0] m_a = 16'h0, m_b = 16'h0;
  logic        p_a = 1'b0,  p_b = 1'b0;

  always #2.5 clk = ~clk;

  adc_readout_mux u0 (
    .clk(clk), .rst_n(rst_n), .conv_a(conv_a), .conv_b(conv_b),
    .xfer_a(xfer_a), .xfer_b(xfer_b), .rd_sel(rd_sel), .rd_en(rd_en),
    .jmp_n(jmp_n), .bus_data(bus_data), .bus_oe(bus_oe)
  );

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual oe/data=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expectation from the bench model
  task automatic step(input logic xa, input logic xb, input logic [15:0] da,
                      input logic [15:0] db, input logic re, input logic [4:0] s,
                      input string tag);
    exp_t e;
    logic req;
    @(negedge clk);
    xfer_a = xa; xfer_b = xb; conv_a = da; conv_b = db;
    rd_en = re; rd_sel = s;
    req  = re && (s[4:1] == ~jmp_n);
    e.oe = req;
    e.d  = req ? (s[0] ? m_b : m_a) : 16'h0;
    e.tag = tag;
    q.push_back(e);
    if (xa && !p_a) m_a = da;
    if (xb && !p_b) m_b = db;
    p_a = xa; p_b = xb;
  endtask

  // Monitor: compares outputs after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, {bus_oe, bus_data}, {e.oe, e.d});
      end
    end
  end

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; xfer_a = 0; xfer_b = 0; conv_a = 0; conv_b = 0;
    rd_en = 0; rd_sel = 0; jmp_n = 4'b1010;
    repeat (3) @(negedge clk);
    check("R10 reset idle", {bus_oe, bus_data}, 17'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: registers read zero after reset (board 5 -> slots 0x0A/0x0B)
    step(0,0,16'h0,16'h0,1,5'h0A,"R10 ch A zero");
    step(0,0,16'h0,16'h0,1,5'h0B,"R10 ch B zero");
    // R1: capture A on rise
    step(1,0,16'h1234,16'h0,0,5'h0A,"R7 idle during capture");
    step(0,0,16'h0,16'h0,1,5'h0A,"R1 read A");
    // R2: capture B, A unchanged
    step(0,1,16'hFFFF,16'hBEEF,0,5'h00,"R7 idle");
    step(0,0,16'h0,16'h0,1,5'h0B,"R2 read B");
    step(0,0,16'h0,16'h0,1,5'h0A,"R2 A unchanged / R4 channel A");
    // R3: strobe held high, data changes
    step(1,0,16'hAAAA,16'h0,0,5'h00,"R7 idle");
    step(1,0,16'h7777,16'h0,1,5'h0A,"R3 held strobe no recapture");
    step(1,0,16'h6666,16'h0,1,5'h0A,"R3 still old value");
    step(0,0,16'h0,16'h0,0,5'h00,"R7 idle");
    // R6: rd_en low with matching select
    step(0,0,16'h0,16'h0,0,5'h0A,"R6 no enable no drive");
    step(0,0,16'h0,16'h0,0,5'h0B,"R6 no enable no drive B");
    // R5: other board slot
    step(0,0,16'h0,16'h0,1,5'h0C,"R5 other board ignored");
    step(0,0,16'h0,16'h0,1,5'h14,"R5 inverted id ignored");
    // R9: same-cycle capture and read
    step(1,0,16'h5555,16'h0,1,5'h0A,"R9 old value on collision");
    step(0,0,16'h0,16'h0,1,5'h0A,"R9 new value next read");
    // R8: back-to-back alternating reads
    step(0,0,16'h0,16'h0,1,5'h0B,"R8 back-to-back B");
    step(0,0,16'h0,16'h0,1,5'h0A,"R8 back-to-back A");
    step(0,0,16'h0,16'h0,0,5'h0A,"R8 drop after one cycle");
    repeat (3) @(negedge clk);

    // R5: board 0
    jmp_n = 4'b1111;
    step(0,0,16'h0,16'h0,1,5'h00,"R5 board 0 ch A");
    step(0,0,16'h0,16'h0,1,5'h01,"R5 board 0 ch B / R4");
    step(0,0,16'h0,16'h0,1,5'h0A,"R5 old slot ignored");
    // R5: board 15
    jmp_n = 4'b0000;
    step(0,1,16'h0,16'h0F0F,0,5'h00,"R7 idle");
    step(0,0,16'h0,16'h0,1,5'h1F,"R5 board 15 ch B");
    step(0,0,16'h0,16'h0,1,5'h1E,"R5 board 15 ch A");
    step(0,0,16'h0,16'h0,1,5'h1D,"R5 neighbour board ignored");
    step(0,0,16'h0,16'h0,0,5'h00,"R7 final idle");
    repeat (4) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule